// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the digital core of a two-wire serial EEPROM. It sits behind an input stage that has already oversampled and synchronised SCL and SDA to the system clock, and it answers a bus master by pulling SDA low through an open-drain enable. It holds a byte-wide array of up to 2K locations addressed with 11 bits. The upper address bits arrive in the address byte together with the device code. The low eight bits arrive in a separate word-address byte.

A write transaction stages its data bytes in a page buffer. Only a STOP moves them into the array, during a timed internal write cycle that ignores the bus entirely. A master learns that the cycle has ended by repeating a START and an address byte until it is acknowledged. Reads come from an internal pointer. A read can start at the current pointer, or at an address loaded by a preceding write-mode address phase and a repeated START. A read continues for as long as the master acknowledges.

The controller has these states: IDLE (bus free), DEV (receiving the address byte), DEV_ACK, WADDR (receiving the word address), WADDR_ACK, WDATA (receiving a data byte), WDATA_ACK, RDATA (sending a byte), RACK (sampling the master's acknowledge), PARK (released, waiting for START or STOP) and BUSY (write cycle). The transitions are as follows:

- START moves any state except BUSY to DEV.
- STOP moves any state except BUSY to BUSY when bytes are staged, and to IDLE otherwise.
- DEV goes to DEV_ACK after eight bits if the code matches, and to PARK if it does not.
- DEV_ACK goes to RDATA for a read or to WADDR for a write.
- WADDR goes to WADDR_ACK, and WADDR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK. RACK goes back to RDATA on an acknowledge, or to PARK on no acknowledge.
- BUSY goes to IDLE after the write-cycle count.

Top module: `i2c_eeprom_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Out of reset, sda_drive_low and busy are 0.
- R2: The address byte is sent MSB first. Bits 7:4 must be 1010, bits 3:1 are address bits 10:8, and bit 0 selects read (1) or write (0). Any other code gets no acknowledge, and the rest of that transaction leaves memory unchanged.
- R3: On the ninth SCL pulse the block holds SDA low after a matching address byte and after every byte received in write mode.
- R4: In a write, each data byte goes to the current address, and then only address bits 3:0 increment. More than 16 bytes wrap within the page and overwrite earlier bytes.
- R5: A STOP after at least one data byte starts a write cycle. Busy is 1 from the clock after the STOP is seen, for exactly WR_CYCLES clocks. During that time START is ignored and SDA is never pulled low. A STOP with no data bytes starts no cycle.
- R6: The pointer holds the address after the last byte accessed: after a write that stays within the page. A read with no word address returns the byte at the pointer.
- R7: A write-mode address phase with a word address loads the pointer with {address byte bits 3:1, word address}. A repeated START then reads from that location.
- R8: Read data leaves MSB first and changes only while SCL is low. An acknowledge (SDA low on the ninth pulse) brings the next byte. No acknowledge releases SDA until the next START or STOP.
- R9: During reads all address bits increment, and 0x7FF is followed by 0x000.
- R10: Only bytes received in the transaction that a STOP ends are written. Other locations in the page keep their contents, and a repeated START discards bytes already staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired bus value) |
| sda_drive_low | output | 1 | 1 pulls the SDA line low |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bus can present a START while the write cycle is still counting, so the end of the busy period and an acknowledge-polling request can meet. The bench issues a poll immediately after a write's STOP, while busy is still 1, and requires no acknowledge. It polls again after the period has ended and requires an acknowledge. A reference model keeps its own countdown from the STOP and compares the busy output on every clock, so it flags a period that is one cycle off at either end.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_PARK, ST_BUSY
    } eep_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_events.sv
// Turns synchronised SCL/SDA levels into single-cycle edge and bus-condition events.
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_rise  = scl_i & ~scl_q;
        ev_fall  = ~scl_i & scl_q;
        ev_start = scl_i & scl_q & sda_q & ~sda_i;
        ev_stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/eep_page_stage.sv
// Page staging buffer: one byte and one valid flag per slot of the page.
module eep_page_stage #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int SLOTS = 2 ** PAGE_W;

    logic [7:0]       slot_data [SLOTS];
    logic [SLOTS-1:0] slot_vld;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_vld[i] <= 1'b0;
            else if (clear)
                slot_vld[i] <= 1'b0;
            else if (wr_en && wr_idx == PAGE_W'(i))
                slot_vld[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PAGE_W'(i))
                slot_data[i] <= wr_data;
        end
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = slot_vld[rd_idx];
    assign any_valid = |slot_vld;
endmodule

// File: rtl/eep_store.sv
// Byte array with one write port and an asynchronous read port.
module eep_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low,
    output logic busy
);
    import eep_pkg::*;

    localparam int HI_W       = ADDR_W - 8;
    localparam int PAGE_BYTES = 2 ** PAGE_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(WR_CYCLES - 1);

    eep_state_e        state, state_nx;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic              rose_q, mack_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  busy_cnt;

    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic stage_we, stage_clear, stage_any, stage_vld;
    logic [7:0] stage_q, mem_rdata;
    logic commit_we, busy_end;

    i2c_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    assign busy_end    = (state == ST_BUSY) && (busy_cnt == BUSY_LAST);
    assign stage_we    = (state == ST_WDATA) && ev_fall && (bitcnt == 4'd8);
    assign stage_clear = (ev_start && state != ST_BUSY) || busy_end;
    assign commit_we   = (state == ST_BUSY) && (busy_cnt < CNT_W'(PAGE_BYTES)) && stage_vld;

    eep_page_stage #(.PAGE_W(PAGE_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (stage_clear),
        .wr_en     (stage_we),
        .wr_idx    (ptr[PAGE_W-1:0]),
        .wr_data   (shreg),
        .rd_idx    (busy_cnt[PAGE_W-1:0]),
        .rd_data   (stage_q),
        .rd_valid  (stage_vld),
        .any_valid (stage_any)
    );

    eep_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (commit_we),
        .waddr ({ptr[ADDR_W-1:PAGE_W], busy_cnt[PAGE_W-1:0]}),
        .wdata (stage_q),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (state == ST_BUSY) begin
            if (busy_end) state_nx = ST_IDLE;
        end else if (ev_start) begin
            state_nx = ST_DEV;
        end else if (ev_stop) begin
            state_nx = stage_any ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state)
                ST_DEV:       if (ev_fall && bitcnt == 4'd8)
                                  state_nx = (shreg[7:4] == DEV_CODE) ? ST_DEV_ACK : ST_PARK;
                ST_DEV_ACK:   if (ev_fall && rose_q)
                                  state_nx = shreg[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (ev_fall && bitcnt == 4'd8) state_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (ev_fall && rose_q) state_nx = ST_WDATA;
                ST_WDATA:     if (ev_fall && bitcnt == 4'd8) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ev_fall && rose_q) state_nx = ST_WDATA;
                ST_RDATA:     if (ev_fall && bitcnt == 4'd7) state_nx = ST_RACK;
                ST_RACK:      if (ev_fall && rose_q) state_nx = mack_q ? ST_RDATA : ST_PARK;
                ST_IDLE, ST_PARK, ST_BUSY: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath: shift register, bit counter, pointer, write-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            rose_q   <= 1'b0;
            mack_q   <= 1'b0;
            hi_q     <= '0;
            ptr      <= '0;
            busy_cnt <= '0;
        end else if (state == ST_BUSY) begin
            busy_cnt <= busy_cnt + CNT_W'(1);
        end else if (ev_start) begin
            bitcnt <= '0;
            rose_q <= 1'b0;
        end else if (ev_stop) begin
            busy_cnt <= '0;
        end else begin
            unique case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (ev_rise) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        rose_q <= 1'b0;
                        if (state == ST_DEV)   hi_q <= shreg[HI_W:1];
                        if (state == ST_WADDR) ptr  <= {hi_q, shreg};
                        if (state == ST_WDATA)
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (ev_rise) begin
                        rose_q <= 1'b1;
                    end else if (ev_fall && rose_q) begin
                        rose_q <= 1'b0;
                        if (state == ST_DEV_ACK && shreg[0]) begin
                            shreg <= mem_rdata;
                            ptr   <= ptr + ADDR_W'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev_fall) begin
                        if (bitcnt == 4'd7) begin
                            bitcnt <= '0;
                            rose_q <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        rose_q <= 1'b1;
                        mack_q <= ~sda_i;
                    end else if (ev_fall && rose_q) begin
                        rose_q <= 1'b0;
                        if (mack_q) begin
                            shreg <= mem_rdata;
                            ptr   <= ptr + ADDR_W'(1);
                        end
                    end
                end
                ST_IDLE, ST_PARK, ST_BUSY: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA: sda_drive_low = ~shreg[7];
            ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_RACK, ST_PARK, ST_BUSY:
                sda_drive_low = 1'b0;
        endcase
        busy = (state == ST_BUSY);
    end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_drive_low,
    input logic busy
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else          run_q <= 0;
    end

    assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_drive_low);

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == WR_CYCLES);

    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(sda_i) && !$past(sda_i, 2) && $past(scl_i) && $past(scl_i, 2)));

    assert_drive_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_i);

    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= WR_CYCLES);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .sda_drive_low (sda_drive_low),
    .busy          (busy)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
    localparam int WRC = 400;
    localparam int Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic drv, busy;
    wire  sda_line = sda_m & ~drv;

    always #10 clk = ~clk;

    i2c_eeprom_target #(.ADDR_W(11), .PAGE_W(4), .WR_CYCLES(WRC)) i_i2c_eeprom_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_drive_low (drv),
        .busy          (busy)
    );

    int n_run = 0, n_fail = 0;
    int busy_left = 0;
    logic mon_on = 1'b0;
    logic [7:0] mem_m [2048];
    int ptr_m = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference busy countdown compared on every clock (R5)
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            chk(busy === (busy_left > 0), "R5 busy window", 32'(busy), 32'(busy_left > 0));
            if (busy_left > 0) busy_left--;
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic i2c_stop(input bit commit);
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1;
        if (commit) busy_left = WRC;
        wait_q();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        acked = ~b;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~give_ack);
    endtask

    function automatic logic [7:0] devb(input logic [10:0] a, input logic rw);
        return {4'b1010, a[10:8], rw};
    endfunction

    task automatic write_txn(input logic [10:0] addr, input logic [7:0] data [$]);
        logic ak;
        i2c_start();
        wbyte(devb(addr, 1'b0), ak); chk(ak, "R3 ack address byte", 32'(ak), 1);
        wbyte(addr[7:0], ak);        chk(ak, "R3 ack word address", 32'(ak), 1);
        foreach (data[i]) begin
            wbyte(data[i], ak);      chk(ak, "R3 ack data byte", 32'(ak), 1);
        end
        i2c_stop(data.size() > 0);
        foreach (data[i])
            mem_m[{addr[10:4], 4'(addr[3:0] + i)}] = data[i];
        ptr_m = {addr[10:4], 4'(addr[3:0] + data.size())};
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        logic b;
        for (int i = 0; i < n; i++) begin
            rbyte(i < n - 1, d);
            chk(d === mem_m[ptr_m], req, 32'(d), 32'(mem_m[ptr_m]));
            ptr_m = (ptr_m + 1) % 2048;
        end
        rbit(b);
        chk(b === 1'b1, "R8 released after no-ack", 32'(b), 1);
        i2c_stop(1'b0);
    endtask

    task automatic read_rand(input logic [10:0] addr, input int n, input string req);
        logic ak;
        i2c_start();
        wbyte(devb(addr, 1'b0), ak); chk(ak, "R3 ack address byte", 32'(ak), 1);
        wbyte(addr[7:0], ak);        chk(ak, "R3 ack word address", 32'(ak), 1);
        i2c_start();
        wbyte(devb(addr, 1'b1), ak); chk(ak, "R7 ack read address", 32'(ak), 1);
        ptr_m = addr;
        read_body(n, req);
    endtask

    task automatic read_cur(input int n, input string req);
        logic ak;
        i2c_start();
        wbyte(devb(11'h0, 1'b1), ak); chk(ak, "R6 ack current read", 32'(ak), 1);
        read_body(n, req);
    endtask

    task automatic wait_cycle();
        repeat (WRC + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic ak;
        logic [7:0] q [$];
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv === 1'b0, "R1 reset sda release", 32'(drv), 0);
        chk(busy === 1'b0, "R1 reset busy", 32'(busy), 0);
        mon_on = 1'b1;

        // byte write, poll while busy, poll after
        q = '{8'hA5};
        write_txn(11'h123, q);
        i2c_start();
        wbyte(devb(11'h123, 1'b0), ak);
        chk(!ak, "R5 no ack while busy", 32'(ak), 0);
        i2c_stop(1'b0);
        wait_cycle();
        i2c_start();
        wbyte(devb(11'h123, 1'b0), ak);
        chk(ak, "R5 ack after cycle", 32'(ak), 1);
        i2c_stop(1'b0);
        repeat (8) @(negedge clk);
        chk(busy === 1'b0, "R5 empty write no cycle", 32'(busy), 0);
        read_rand(11'h123, 1, "R7 random read");

        // full page at the top of the array, pointer wraps inside the page
        q = {};
        for (int i = 0; i < 16; i++) q.push_back(8'(i * 7 + 3));
        write_txn(11'h7F0, q);
        wait_cycle();
        read_cur(2, "R6 current read after page wrap");
        read_rand(11'h7F0, 16, "R8 sequential read");

        // 18 bytes from offset 5: last two overwrite
        q = {};
        for (int i = 0; i < 18; i++) q.push_back(8'(8'h40 + i));
        write_txn(11'h205, q);
        wait_cycle();
        read_rand(11'h200, 16, "R4 page rollover");

        // partial page update
        q = '{8'hC1, 8'hC2, 8'hC3};
        write_txn(11'h20A, q);
        wait_cycle();
        read_rand(11'h200, 16, "R10 partial page");

        // array wrap on reads
        q = {};
        for (int i = 0; i < 16; i++) q.push_back(8'(8'h90 ^ i));
        write_txn(11'h000, q);
        wait_cycle();
        read_rand(11'h7FE, 4, "R9 read wraps to zero");

        // wrong device code
        i2c_start();
        wbyte(8'hB6, ak); chk(!ak, "R2 foreign code no ack", 32'(ak), 0);
        wbyte(8'h23, ak); chk(!ak, "R2 ignored word", 32'(ak), 0);
        wbyte(8'h00, ak); chk(!ak, "R2 ignored data", 32'(ak), 0);
        i2c_stop(1'b0);
        repeat (8) @(negedge clk);
        read_rand(11'h123, 1, "R2 memory unchanged");

        // repeated START discards staged byte
        i2c_start();
        wbyte(devb(11'h7F5, 1'b0), ak); chk(ak, "R3 ack address byte", 32'(ak), 1);
        wbyte(8'hF5, ak);               chk(ak, "R3 ack word address", 32'(ak), 1);
        wbyte(8'h00, ak);               chk(ak, "R3 ack data byte", 32'(ak), 1);
        i2c_start();
        wbyte(devb(11'h7F5, 1'b0), ak); chk(ak, "R3 ack address byte", 32'(ak), 1);
        wbyte(8'hF5, ak);               chk(ak, "R3 ack word address", 32'(ak), 1);
        i2c_start();
        wbyte(devb(11'h7F5, 1'b1), ak); chk(ak, "R7 ack read address", 32'(ak), 1);
        rbyte(1'b0, d);
        chk(d === mem_m[11'h7F5], "R10 restart discards staged byte", 32'(d), 32'(mem_m[11'h7F5]));
        i2c_stop(1'b0);
        repeat (20) @(negedge clk);
        ptr_m = 11'h7F6;
        read_cur(1, "R6 pointer after restart read");

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule